// File: doc/BRIEF.md
# Firmware-Cycle Address Remap Window

This block translates firmware-space addresses from a host into addresses on a local bus. A host firmware-space address comes in with a valid strobe. One clock later the block gives three results: whether the address falls inside the programmed window, the local address it maps to, and whether the access may be forwarded.

Software sets up the window through four 32-bit registers on a simple read/write register bus. The low 16 address bits always pass through unchanged. The upper 16 bits are handled with two masks. The replace mask marks upper bits that are decided by the window: those bits are compared against the host base, and in the result they come from the local base. The keep mask marks upper bits that are copied from the request into the local address. As a result, a window is a multiple of 64 KiB and starts at an offset that is a multiple of its own size.

A mode register holds one mode bit. Its other bits are status flags. A hardware pulse sets a status flag, and software clears it by writing a one.

Top module: `fwh_remap_window`

## Requirements
- R1: After reset all four registers read 0, and hit_o, fwd_en_o and local_addr_o are 0.
- R2: Register access uses the byte offset, and only offsets with bits [1:0] equal to 0 have an effect. Offset 0x0 is the enable register, offset 0x4 the mode/status register, offset 0x8 the base register and offset 0xC the mask register. In the enable register only bit 8 (forward enable) and bit 10 (firmware-cycle enable) are stored; every other bit reads 0. The base and mask registers store all 32 bits. Read data appears on reg_rdata_o in the cycle after reg_rd_i and is held until the next read.
- R3: A valid request hits when its address bits [31:16], ANDed with mask bits [31:16], equal base bits [15:0] ANDed with the same mask bits.
- R4: On a hit, local_addr_o[31:16] is (base[31:16] AND mask[31:16]) OR (request[31:16] AND mask[15:0]).
- R5: On a hit, local_addr_o[15:0] equals request bits [15:0].
- R6: The outputs are registered with one clock of latency. A cycle without req_valid_i gives 0 on all three outputs in the next cycle.
- R7: A valid request that misses gives hit_o = 0, fwd_en_o = 0 and local_addr_o = 0.
- R8: fwd_en_o is 1 only for a hit while enable bits 8 and 10 are both 1.
- R9: Bit 17 of the mode register is a read/write mode bit and drives fwh_mode_o.
- R10: Every bit of the mode register other than 17 is a status bit. Writing 1 to a status bit clears it; writing 0 leaves it unchanged. A status bit is set only by a pulse on the matching bit of stat_set_i.
- R11: If a set pulse and a write-one-to-clear hit the same status bit in the same clock, the bit ends up set.
- R12: A pulse on stat_set_i[17] does not affect the mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, one cycle after the read strobe |
| stat_set_i | input | 32 | Status set pulses, one per status bit |
| req_valid_i | input | 1 | Host request valid |
| req_addr_i | input | 32 | Host firmware-space address |
| hit_o | output | 1 | Request fell inside the window |
| fwd_en_o | output | 1 | Translated access may be forwarded |
| local_addr_o | output | 32 | Translated local address |
| fwh_mode_o | output | 1 | Mode bit 17 of the mode register |

## Verification
The bench uses the default parameters: 32-bit addresses and a 16-bit pass-through offset. With these values the replace and keep fields are each 16 bits wide. That makes a 2 MiB window small enough to place requests on its last 64 KiB unit and on the units just outside both of its edges. Because the register width is 32, the bench can also place status bits on both sides of bit 17, test a set pulse and a clear on the same bit in the same cycle, and test a pulse on the mode bit position itself.

// File: rtl/fwh_remap_pkg.sv
package fwh_remap_pkg;

  localparam int unsigned REG_OFS_W = 4;

  // Bit positions decoded by software; keep fixed.
  localparam int unsigned FWD_BIT  = 8;
  localparam int unsigned FWH_BIT  = 10;
  localparam int unsigned MODE_BIT = 17;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_MODE   = 2'd1,
    SEL_BASE   = 2'd2,
    SEL_MASK   = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/fwh_remap_regs.sv
module fwh_remap_regs
  import fwh_remap_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [REG_OFS_W-1:0] reg_addr_i,
  input  logic                 reg_wr_i,
  input  logic                 reg_rd_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  input  logic [DATA_W-1:0]    stat_set_i,
  output logic                 en_fwd_o,
  output logic                 en_fwh_o,
  output logic                 mode_o,
  output logic [DATA_W-1:0]    stat_o,
  output logic [DATA_W-1:0]    base_o,
  output logic [DATA_W-1:0]    mask_o
);

  localparam logic [DATA_W-1:0] STAT_MASK = ~(DATA_W'(1) << MODE_BIT);

  logic              aligned;
  reg_sel_e          sel;
  logic              wr_enable, wr_mode, wr_base, wr_mask;
  logic              en_fwd_q, en_fwd_d;
  logic              en_fwh_q, en_fwh_d;
  logic              mode_q, mode_d;
  logic [DATA_W-1:0] stat_q, stat_d;
  logic [DATA_W-1:0] set_eff;
  logic [DATA_W-1:0] base_q, mask_q;
  logic [DATA_W-1:0] rd_mux, rdata_q, rdata_d;

  // Decode
  always_comb begin
    aligned   = (reg_addr_i[1:0] == 2'b00);
    sel       = reg_sel_e'(reg_addr_i[3:2]);
    wr_enable = reg_wr_i && aligned && (sel == SEL_ENABLE);
    wr_mode   = reg_wr_i && aligned && (sel == SEL_MODE);
    wr_base   = reg_wr_i && aligned && (sel == SEL_BASE);
    wr_mask   = reg_wr_i && aligned && (sel == SEL_MASK);
  end

  // Next state of enable and mode bits
  always_comb begin
    en_fwd_d = wr_enable ? reg_wdata_i[FWD_BIT] : en_fwd_q;
    en_fwh_d = wr_enable ? reg_wdata_i[FWH_BIT] : en_fwh_q;
    mode_d   = wr_mode   ? reg_wdata_i[MODE_BIT] : mode_q;
  end

  assign set_eff = stat_set_i & STAT_MASK;

  // Status flags: set has priority over write-one-to-clear
  for (genvar b = 0; b < DATA_W; b++) begin : g_stat
    if (b == MODE_BIT) begin : g_hole
      assign stat_d[b] = 1'b0;
    end else begin : g_flag
      assign stat_d[b] = set_eff[b] | (stat_q[b] & ~(wr_mode & reg_wdata_i[b]));
    end
  end

  // Read mux
  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      unique case (sel)
        SEL_ENABLE: begin
          rd_mux[FWD_BIT] = en_fwd_q;
          rd_mux[FWH_BIT] = en_fwh_q;
        end
        SEL_MODE: begin
          rd_mux           = stat_q;
          rd_mux[MODE_BIT] = mode_q;
        end
        SEL_BASE: rd_mux = base_q;
        SEL_MASK: rd_mux = mask_q;
        default:  rd_mux = '0;
      endcase
    end
    rdata_d = reg_rd_i ? rd_mux : rdata_q;
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_fwd_q <= 1'b0;
      en_fwh_q <= 1'b0;
      mode_q   <= 1'b0;
      stat_q   <= '0;
      rdata_q  <= '0;
    end else begin
      en_fwd_q <= en_fwd_d;
      en_fwh_q <= en_fwh_d;
      mode_q   <= mode_d;
      stat_q   <= stat_d;
      rdata_q  <= rdata_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
    end else if (wr_base) begin
      base_q <= reg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (wr_mask) begin
      mask_q <= reg_wdata_i;
    end
  end

  assign reg_rdata_o = rdata_q;
  assign en_fwd_o    = en_fwd_q;
  assign en_fwh_o    = en_fwh_q;
  assign mode_o      = mode_q;
  assign stat_o      = stat_q;
  assign base_o      = base_q;
  assign mask_o      = mask_q;

endmodule

// File: rtl/fwh_remap_xlate.sv
module fwh_remap_xlate #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned GRAN_BITS = 16,
  localparam int unsigned UP_W     = ADDR_W - GRAN_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [UP_W-1:0]   local_base_i,
  input  logic [UP_W-1:0]   host_base_i,
  input  logic [UP_W-1:0]   repl_mask_i,
  input  logic [UP_W-1:0]   keep_mask_i,
  input  logic              en_fwd_i,
  input  logic              en_fwh_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              hit_o,
  output logic              fwd_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic [UP_W-1:0]   req_up;
  logic [UP_W-1:0]   new_up;
  logic              match;
  logic              hit_d, hit_q;
  logic              fwd_d, fwd_q;
  logic [ADDR_W-1:0] addr_d, addr_q;

  always_comb begin
    req_up = req_addr_i[ADDR_W-1:GRAN_BITS];
    match  = (((req_up ^ host_base_i) & repl_mask_i) == '0);
    new_up = (local_base_i & repl_mask_i) | (req_up & keep_mask_i);
    hit_d  = req_valid_i && match;
    fwd_d  = hit_d && en_fwd_i && en_fwh_i;
    addr_d = hit_d ? {new_up, req_addr_i[GRAN_BITS-1:0]} : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      fwd_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      hit_q  <= hit_d;
      fwd_q  <= fwd_d;
      addr_q <= addr_d;
    end
  end

  assign hit_o  = hit_q;
  assign fwd_o  = fwd_q;
  assign addr_o = addr_q;

endmodule

// File: rtl/fwh_remap_window.sv
module fwh_remap_window
  import fwh_remap_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned GRAN_BITS = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [REG_OFS_W-1:0] reg_addr_i,
  input  logic                 reg_wr_i,
  input  logic                 reg_rd_i,
  input  logic [ADDR_W-1:0]    reg_wdata_i,
  output logic [ADDR_W-1:0]    reg_rdata_o,
  input  logic [ADDR_W-1:0]    stat_set_i,
  input  logic                 req_valid_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  output logic                 hit_o,
  output logic                 fwd_en_o,
  output logic [ADDR_W-1:0]    local_addr_o,
  output logic                 fwh_mode_o
);

  localparam int unsigned DATA_W = ADDR_W;
  localparam int unsigned UP_W   = ADDR_W - GRAN_BITS;

  logic              en_fwd, en_fwh, mode;
  logic [DATA_W-1:0] stat_q, base_q, mask_q;

  fwh_remap_regs #(
    .DATA_W (DATA_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .stat_set_i  (stat_set_i),
    .en_fwd_o    (en_fwd),
    .en_fwh_o    (en_fwh),
    .mode_o      (mode),
    .stat_o      (stat_q),
    .base_o      (base_q),
    .mask_o      (mask_q)
  );

  fwh_remap_xlate #(
    .ADDR_W    (ADDR_W),
    .GRAN_BITS (GRAN_BITS)
  ) u_xlate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .local_base_i (base_q[DATA_W-1 -: UP_W]),
    .host_base_i  (base_q[UP_W-1:0]),
    .repl_mask_i  (mask_q[DATA_W-1 -: UP_W]),
    .keep_mask_i  (mask_q[UP_W-1:0]),
    .en_fwd_i     (en_fwd),
    .en_fwh_i     (en_fwh),
    .req_valid_i  (req_valid_i),
    .req_addr_i   (req_addr_i),
    .hit_o        (hit_o),
    .fwd_o        (fwd_en_o),
    .addr_o       (local_addr_o)
  );

  assign fwh_mode_o = mode;

endmodule

// File: rtl/fwh_remap_checks.sv
module fwh_remap_checks
  import fwh_remap_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned GRAN_BITS = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] stat_set_i,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              hit_o,
  input logic              fwd_en_o,
  input logic [ADDR_W-1:0] local_addr_o,
  input logic              en_fwd,
  input logic              en_fwh,
  input logic [ADDR_W-1:0] stat_q
);

  localparam logic [ADDR_W-1:0] STAT_MASK = ~(ADDR_W'(1) << MODE_BIT);

  // R6: no request, quiet outputs next cycle
  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_valid_i) |-> (!hit_o && !fwd_en_o && local_addr_o == '0));

  // R7: outputs zero without a hit
  p_miss_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (!fwd_en_o && local_addr_o == '0));

  // R8: forwarding needs a hit
  p_fwd_hit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_en_o |-> hit_o);

  // R8: forwarding needs both enables
  p_fwd_enables_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_en_o |-> $past(en_fwd && en_fwh));

  // R5: offset bits pass through
  p_low_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (local_addr_o[GRAN_BITS-1:0] == $past(req_addr_i[GRAN_BITS-1:0])));

  // R11: a set pulse always lands
  p_set_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_set_i & STAT_MASK) != '0) |=>
      ((stat_q & $past(stat_set_i & STAT_MASK)) == $past(stat_set_i & STAT_MASK)));

  // R10: status bits rise only on a set pulse
  p_rise_by_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q & ~$past(stat_q) & ~$past(stat_set_i)) == '0);

  // R10: status bits fall only after a register write
  p_fall_by_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(stat_q) & ~stat_q) != '0) |-> $past(reg_wr_i));

endmodule

bind fwh_remap_window fwh_remap_checks #(
  .ADDR_W    (ADDR_W),
  .GRAN_BITS (GRAN_BITS)
) u_checks (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_wr_i     (reg_wr_i),
  .stat_set_i   (stat_set_i),
  .req_valid_i  (req_valid_i),
  .req_addr_i   (req_addr_i),
  .hit_o        (hit_o),
  .fwd_en_o     (fwd_en_o),
  .local_addr_o (local_addr_o),
  .en_fwd       (en_fwd),
  .en_fwh       (en_fwh),
  .stat_q       (stat_q)
);

// File: tb/fwh_remap_window_bench.sv
module fwh_remap_window_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    int          cyc;
    int          rq;
    logic        hit;
    logic        fwd;
    logic [31:0] addr;
  } exp_t;

  logic        clk, rst_n;
  logic [3:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [31:0] reg_wdata, reg_rdata, stat_set, req_addr, local_addr;
  logic        req_valid, hit, fwd_en, fwh_mode;

  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  exp_t sb_q[$];

  logic [31:0] sh_base = '0;
  logic [31:0] sh_mask = '0;
  logic        sh_fwd = 1'b0;
  logic        sh_fwh = 1'b0;

  fwh_remap_window u_fwh_remap_window (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .reg_addr_i   (reg_addr),
    .reg_wr_i     (reg_wr),
    .reg_rd_i     (reg_rd),
    .reg_wdata_i  (reg_wdata),
    .reg_rdata_o  (reg_rdata),
    .stat_set_i   (stat_set),
    .req_valid_i  (req_valid),
    .req_addr_i   (req_addr),
    .hit_o        (hit),
    .fwd_en_o     (fwd_en),
    .local_addr_o (local_addr),
    .fwh_mode_o   (fwh_mode)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Expected result from the requirements R3, R4, R5, R7, R8
  function automatic exp_t model(input logic v, input logic [31:0] a, input int rq);
    exp_t        e;
    logic [15:0] up;
    e.cyc = 0;
    e.rq  = rq;
    up    = a[31:16];
    e.hit = v && ((up & sh_mask[31:16]) == (sh_base[15:0] & sh_mask[31:16]));
    e.fwd = e.hit && sh_fwd && sh_fwh;
    e.addr = e.hit ? {(sh_base[31:16] & sh_mask[31:16]) | (up & sh_mask[15:0]), a[15:0]} : 32'h0;
    return e;
  endfunction

  // Driver: one request slot per call
  task automatic send(input logic v, input logic [31:0] a, input int rq);
    exp_t e;
    @(posedge clk); #1;
    req_valid = v;
    req_addr  = a;
    e = model(v, a, rq);
    e.cyc = cyc;
    sb_q.push_back(e);
  endtask

  // Monitor: compare one cycle after each driven slot
  always @(negedge clk) begin
    if (rst_n) begin
      while (sb_q.size() > 0 && sb_q[0].cyc == cyc - 1) begin
        exp_t e;
        e = sb_q.pop_front();
        check(hit == e.hit, $sformatf("R%0d hit", e.rq), {31'b0, hit}, {31'b0, e.hit});
        check(fwd_en == e.fwd, $sformatf("R%0d fwd", e.rq), {31'b0, fwd_en}, {31'b0, e.fwd});
        check(local_addr == e.addr, $sformatf("R%0d addr", e.rq), local_addr, e.addr);
      end
    end
  end

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d, input logic [31:0] st);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; stat_set = st;
    @(posedge clk); #1;
    reg_wr = 1'b0; stat_set = '0;
  endtask

  task automatic pulse_set(input logic [31:0] st);
    @(posedge clk); #1;
    stat_set = st;
    @(posedge clk); #1;
    stat_set = '0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_rd = 1'b1;
    @(posedge clk); #1;
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [31:0] exp, input string rq);
    logic [31:0] d;
    reg_read(a, d);
    check(d == exp, rq, d, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    reg_wdata = '0; stat_set = '0; req_valid = 1'b0; req_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs during reset
    check(!hit && !fwd_en && local_addr == 0, "R1 outputs in reset", local_addr, 32'h0);
    rst_n = 1'b1;

    // R1: registers read zero
    expect_reg(4'h0, 32'h0, "R1 enable");
    expect_reg(4'h4, 32'h0, "R1 mode");
    expect_reg(4'h8, 32'h0, "R1 base");
    expect_reg(4'hC, 32'h0, "R1 mask");

    // R2: map and stored bits
    reg_write(4'h0, 32'hFFFF_FFFF, '0);
    expect_reg(4'h0, 32'h0000_0500, "R2 enable bits");
    reg_write(4'h0, 32'h0, '0);
    reg_write(4'h8, 32'h9800_0E00, '0);
    expect_reg(4'h8, 32'h9800_0E00, "R2 base");
    reg_write(4'hC, 32'hFFE0_001F, '0);
    expect_reg(4'hC, 32'hFFE0_001F, "R2 mask");
    reg_write(4'h9, 32'h1234_5678, '0); // misaligned: no effect
    expect_reg(4'h8, 32'h9800_0E00, "R2 misaligned write");
    sh_base = 32'h9800_0E00;
    sh_mask = 32'hFFE0_001F;

    // R9: mode bit
    reg_write(4'h4, 32'hFFFF_FFFF, '0);
    expect_reg(4'h4, 32'h0002_0000, "R9 mode readback");
    check(fwh_mode == 1'b1, "R9 mode pin", {31'b0, fwh_mode}, 32'h1);

    // R3 R4 R5 R7: translation with enables off (R8)
    send(1'b1, 32'h0E12_3456, 4);
    send(1'b1, 32'h0E1F_FFFF, 3);
    send(1'b1, 32'h0E20_0000, 7);
    send(1'b1, 32'h0DFF_FFFF, 7);
    send(1'b1, 32'h0E00_0000, 5);
    send(1'b0, 32'h0E12_3456, 6);
    send(1'b0, 32'h0, 6);

    // R8: one enable only
    reg_write(4'h0, 32'h0000_0100, '0);
    sh_fwd = 1'b1;
    send(1'b1, 32'h0E05_ABCD, 8);
    send(1'b0, 32'h0, 6);
    reg_write(4'h0, 32'h0000_0400, '0);
    sh_fwd = 1'b0; sh_fwh = 1'b1;
    send(1'b1, 32'h0E05_ABCD, 8);
    send(1'b0, 32'h0, 6);
    reg_write(4'h0, 32'h0000_0500, '0);
    sh_fwd = 1'b1;
    send(1'b1, 32'h0E05_ABCD, 8);
    send(1'b1, 32'h0E1A_0001, 4);
    send(1'b1, 32'h1E05_0000, 7);
    send(1'b0, 32'h0E05_ABCD, 6);

    // R3: replace mask empty, keep all -> identity
    reg_write(4'hC, 32'h0000_FFFF, '0);
    sh_mask = 32'h0000_FFFF;
    send(1'b1, 32'hCAFE_F00D, 3);
    send(1'b0, 32'h0, 6);
    repeat (3) @(posedge clk);

    // R10: status set, write-zero keeps, write-one clears
    pulse_set(32'h0000_0011);
    expect_reg(4'h4, 32'h0002_0011, "R10 set");
    reg_write(4'h4, 32'h0002_0000, '0);
    expect_reg(4'h4, 32'h0002_0011, "R10 write zero");
    reg_write(4'h4, 32'h0000_0001, '0);
    expect_reg(4'h4, 32'h0000_0010, "R10 clear one");
    check(fwh_mode == 1'b0, "R9 mode cleared", {31'b0, fwh_mode}, 32'h0);

    // R11: set and clear in the same clock
    reg_write(4'h4, 32'h0000_0010, 32'h0000_0010);
    expect_reg(4'h4, 32'h0000_0010, "R11 set wins");

    // R12: pulse on the mode position
    pulse_set(32'h0002_0000);
    expect_reg(4'h4, 32'h0000_0010, "R12 mode untouched");
    check(fwh_mode == 1'b0, "R12 mode pin", {31'b0, fwh_mode}, 32'h0);
    reg_write(4'h4, 32'h8000_0010, 32'h8000_0000);
    expect_reg(4'h4, 32'h8000_0000, "R10 high status bit");

    repeat (3) @(posedge clk);
    check(sb_q.size() == 0, "R6 scoreboard drained", sb_q.size(), 32'h0);
    finish_run();
  end

endmodule